// File: doc/BRIEF.md
# Banked Priority Interrupt Controller

This block gathers up to thirty interrupt sources into four byte-wide banks. Two of them are general-purpose banks, called A and B. One is a six-source DMA bank. The last is a fast-interrupt bank. Software reads and programs each bank through a small byte-wide register bus. Each bank offers three views:

- a raw status register;
- a masked request register (status AND mask);
- a mask register.

Bank A sources are edge-latched and must be acknowledged by a write-one-to-clear. The other three banks simply follow the level of their inputs.

An `irq` line is raised while any request is pending in banks A, B or DMA. A separate `fiq` line is raised while the fast-interrupt bank has a request. A registered priority resolver looks at the requests in a fixed order: bank B first, then DMA, then bank A. It reports the winning global interrupt number together with a valid flag. The valid flag is needed because number 0 is a real source. Inside banks A and B the winner follows a fixed, non-monotonic bit ranking. Inside the DMA bank the lowest bit wins.

Top module: `prio_intc`

## Requirements
- R1: After reset all four mask registers read 0, and `irq`, `fiq` and `int_valid` are low.
- R2: `reg_addr[5:4]` selects the bank: 0 = A, 1 = B, 2 = DMA, 3 = fast. `reg_addr[3:0]` selects the register: 0x0 reads status, 0x4 reads request (status AND mask), 0x8 reads and writes the mask. Other offsets read 0. DMA bits 7:6 always read 0.
- R3: A rising edge on a bank A input sets its status bit on the next clock. The bit stays set after the input falls.
- R4: Writing to bank A at offset 0x4 clears each status bit whose data bit is 1. Data bits that are 0 leave their status bits unchanged. A new rising edge in the same cycle wins over the clear.
- R5: Status bits of banks B, DMA and fast equal their inputs as sampled on the previous clock. Writes to their 0x4 offset change nothing.
- R6: `irq` is high exactly when a request bit is set in bank A, B or DMA. `fiq` is high exactly when a fast-bank request bit is set.
- R7: The resolver takes the winner from bank B if it has any request. Otherwise it takes the winner from DMA, and otherwise from bank A. Fast-bank requests never affect `int_valid` or `int_num`.
- R8: Inside bank B the bits rank, from highest to lowest: 2, 3, 5, 7, 6, 0, 1, 4. Bank B bit n is reported as number 8+n.
- R9: Inside bank A the bits rank, from highest to lowest: 7, 5, 3, 6, 2, 0, 1, 4. Bank A bit n is reported as number n.
- R10: Inside the DMA bank the lowest set bit wins. DMA bit n is reported as number 16+n.
- R11: `int_valid` and `int_num` are registered. They reflect the requests visible on the bus one clock earlier. `int_valid` is 0 when no request was pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register bus |
| reg_addr | input | 6 | Bank select [5:4] and register offset [3:0] |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| src_a | input | 8 | Bank A sources (edge-latched) |
| src_b | input | 8 | Bank B sources (level) |
| src_dma | input | 6 | DMA sources (level) |
| src_fiq | input | 8 | Fast-interrupt sources (level) |
| irq | output | 1 | Any request pending in A, B or DMA |
| fiq | output | 1 | Any fast-bank request pending |
| int_valid | output | 1 | Resolver found a winner |
| int_num | output | 5 | Global number of the winner |

## Verification
The random patterns drive all banks at once with dense, overlapping bits. This shows whether the bank scan order is right and whether each in-bank ranking is right, since a lowest-bit-first or monotonic rule gives different numbers on most multi-bit requests.

Directed patterns cover the cases random data rarely produces:
- single-bit and paired-bit requests that walk each ranking;
- a pulse on bank A that falls before it is read back, which separates edge latching from level following;
- a clear that lands together with a new edge;
- clears aimed at level banks;
- requests that exist only in the fast bank, which must leave the resolver idle.

// File: rtl/intc_pkg.sv
// Shared constants, types and ranking functions for the banked interrupt
// controller. Assumes byte-wide banks and a 6-bit register address.
package intc_pkg;

    localparam int BANK_W = 8;
    localparam int DMA_W  = 6;
    localparam int ADDR_W = 6;
    localparam int NUM_W  = 5;
    localparam int IDX_W  = $clog2(BANK_W);

    typedef enum logic [1:0] {
        BK_A   = 2'd0,
        BK_B   = 2'd1,
        BK_DMA = 2'd2,
        BK_FIQ = 2'd3
    } bank_e;

    localparam logic [3:0] OFF_STAT = 4'h0;
    localparam logic [3:0] OFF_REQ  = 4'h4;
    localparam logic [3:0] OFF_MASK = 4'h8;

    localparam logic [NUM_W-1:0] BASE_A   = NUM_W'(0);
    localparam logic [NUM_W-1:0] BASE_B   = NUM_W'(8);
    localparam logic [NUM_W-1:0] BASE_DMA = NUM_W'(16);

    // Ranking tables: element [0] is the highest-priority bit.
    typedef logic [BANK_W-1:0][IDX_W-1:0] rank_t;
    localparam rank_t RANK_A = {3'd4, 3'd1, 3'd0, 3'd2, 3'd6, 3'd3, 3'd5, 3'd7};
    localparam rank_t RANK_B = {3'd4, 3'd1, 3'd0, 3'd6, 3'd7, 3'd5, 3'd3, 3'd2};

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
    } pick_t;

    // Highest-ranked set bit according to a ranking table.
    function automatic pick_t pick_ranked(input logic [BANK_W-1:0] req, input rank_t rank);
        pick_t p;
        p = '0;
        for (int i = BANK_W - 1; i >= 0; i--) begin
            if (req[rank[i]]) begin
                p.hit = 1'b1;
                p.idx = rank[i];
            end
        end
        return p;
    endfunction

    // Lowest-numbered set bit.
    function automatic pick_t pick_lowest(input logic [BANK_W-1:0] req);
        pick_t p;
        p = '0;
        for (int i = BANK_W - 1; i >= 0; i--) begin
            if (req[i]) begin
                p.hit = 1'b1;
                p.idx = IDX_W'(i);
            end
        end
        return p;
    endfunction

endpackage

// File: rtl/intc_bank.sv
// One interrupt source bank: status, mask and masked request.
// LATCH=1 makes status edge-latched with write-one-to-clear; LATCH=0 makes
// status follow the input level one clock later and ignores clears.
// LIVE marks the implemented bits; the others always read zero.
module intc_bank
    import intc_pkg::*;
#(
    parameter bit               LATCH = 1'b0,
    parameter logic [BANK_W-1:0] LIVE = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] src,
    input  logic              mask_we,
    input  logic              clr_we,
    input  logic [BANK_W-1:0] wdata,
    output logic [BANK_W-1:0] status,
    output logic [BANK_W-1:0] mask,
    output logic [BANK_W-1:0] req
);

    logic [BANK_W-1:0] status_q;
    logic [BANK_W-1:0] mask_q;

    // Mask register, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_we) mask_q <= wdata & LIVE;
    end

    generate
        if (LATCH) begin : g_latch
            logic [BANK_W-1:0] prev_q;
            logic [BANK_W-1:0] edge_v;
            logic [BANK_W-1:0] clr_v;

            // Rising-edge detect and clear vector.
            always_comb begin
                edge_v = src & ~prev_q & LIVE;
                clr_v  = clr_we ? (wdata & LIVE) : '0;
            end

            // Latched status: a new edge beats a clear in the same cycle.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    prev_q   <= '0;
                    status_q <= '0;
                end else begin
                    prev_q   <= src & LIVE;
                    status_q <= (status_q & ~clr_v) | edge_v;
                end
            end

            // R3: a set bit that was not cleared stays set.
            a_r3_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> ((status_q & $past(status_q & ~clr_v)) == $past(status_q & ~clr_v)));
            // R4: cleared bits without a competing edge read zero next cycle.
            a_r4_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
                clr_we |=> ((status_q & $past(clr_v & ~edge_v)) == '0));
            // R4: an edge always lands, even against a clear.
            a_r4_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
                (edge_v != '0) |=> ((status_q & $past(edge_v)) == $past(edge_v)));
        end else begin : g_level
            logic unused_clr;
            assign unused_clr = clr_we;

            // Level status: sample the inputs every clock.
            always_ff @(posedge clk) begin
                if (!rst_n) status_q <= '0;
                else        status_q <= src & LIVE;
            end

            // R5: status tracks the inputs and no clear ever applies.
            a_r5_level_follow: assert property (@(posedge clk) disable iff (!rst_n)
                clr_we |=> (status_q == ($past(src) & LIVE)));
        end
    endgenerate

    // Outputs of the bank.
    always_comb begin
        status = status_q;
        mask   = mask_q;
        req    = status_q & mask_q;
    end

    // R1: masks come out of reset cleared.
    a_r1_mask_reset: assert property (@(posedge clk) !rst_n |=> (mask_q == '0));

endmodule

// File: rtl/intc_resolver.sv
// Registered priority resolver. Scans bank B, then DMA, then bank A, and
// reports the global number of the winner with a valid flag.
// Assumes requests are already masked.
module intc_resolver
    import intc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] req_a,
    input  logic [BANK_W-1:0] req_b,
    input  logic [DMA_W-1:0]  req_dma,
    output logic              int_valid,
    output logic [NUM_W-1:0]  int_num
);

    pick_t            pk_a, pk_b, pk_d;
    logic             nxt_valid;
    logic [NUM_W-1:0] nxt_num;

    // Per-bank winners and bank-order selection.
    always_comb begin
        pk_b = pick_ranked(req_b, RANK_B);
        pk_d = pick_lowest({{(BANK_W-DMA_W){1'b0}}, req_dma});
        pk_a = pick_ranked(req_a, RANK_A);
        nxt_valid = pk_b.hit | pk_d.hit | pk_a.hit;
        if (pk_b.hit)      nxt_num = BASE_B   + NUM_W'(pk_b.idx);
        else if (pk_d.hit) nxt_num = BASE_DMA + NUM_W'(pk_d.idx);
        else if (pk_a.hit) nxt_num = BASE_A   + NUM_W'(pk_a.idx);
        else               nxt_num = '0;
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_valid <= 1'b0;
            int_num   <= '0;
        end else begin
            int_valid <= nxt_valid;
            int_num   <= nxt_num;
        end
    end

    // R11: nothing pending means no valid result next cycle.
    a_r11_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (req_a == '0 && req_b == '0 && req_dma == '0) |=> !int_valid);
    // R7: bank B wins whenever it has a request.
    a_r7_b_first: assert property (@(posedge clk) disable iff (!rst_n)
        (req_b != '0) |=> (int_valid && int_num >= BASE_B && int_num < BASE_DMA));
    // R7: DMA beats bank A.
    a_r7_dma_before_a: assert property (@(posedge clk) disable iff (!rst_n)
        (req_b == '0 && req_dma != '0) |=> (int_valid && int_num >= BASE_DMA));
    // R10: DMA bit 0 is the top DMA source.
    a_r10_dma_low: assert property (@(posedge clk) disable iff (!rst_n)
        (req_b == '0 && req_dma[0]) |=> (int_num == BASE_DMA));
    // R9: bank A bit 7 is the top bank A source.
    a_r9_a_top: assert property (@(posedge clk) disable iff (!rst_n)
        (req_b == '0 && req_dma == '0 && req_a[7]) |=> (int_num == NUM_W'(7)));

endmodule

// File: rtl/prio_intc.sv
// Banked interrupt controller top: four source banks on a byte-wide register
// bus, irq/fiq summary lines and a registered priority resolver.
// Assumes a single clock domain and inputs already synchronous to clk.
module prio_intc
    import intc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic [7:0]        src_a,
    input  logic [7:0]        src_b,
    input  logic [5:0]        src_dma,
    input  logic [7:0]        src_fiq,
    output logic              irq,
    output logic              fiq,
    output logic              int_valid,
    output logic [NUM_W-1:0]  int_num
);

    localparam int N_BANK = 4;

    logic [BANK_W-1:0] src_v [N_BANK];
    logic [BANK_W-1:0] st_v  [N_BANK];
    logic [BANK_W-1:0] mk_v  [N_BANK];
    logic [BANK_W-1:0] rq_v  [N_BANK];
    logic [1:0]        sel_bank;
    logic [3:0]        sel_off;

    // Address split and source padding.
    always_comb begin
        sel_bank = reg_addr[5:4];
        sel_off  = reg_addr[3:0];
        src_v[BK_A]   = src_a;
        src_v[BK_B]   = src_b;
        src_v[BK_DMA] = {{(BANK_W-DMA_W){1'b0}}, src_dma};
        src_v[BK_FIQ] = src_fiq;
    end

    generate
        for (genvar g = 0; g < N_BANK; g++) begin : g_bank
            localparam bit               IS_LATCH = (g == BK_A);
            localparam logic [BANK_W-1:0] LIVE_M  = (g == BK_DMA) ?
                BANK_W'((1 << DMA_W) - 1) : '1;
            logic hit;
            assign hit = reg_wr && (sel_bank == 2'(g));
            intc_bank #(.LATCH(IS_LATCH), .LIVE(LIVE_M)) u_bank (
                .clk     (clk),
                .rst_n   (rst_n),
                .src     (src_v[g]),
                .mask_we (hit && sel_off == OFF_MASK),
                .clr_we  (hit && sel_off == OFF_REQ),
                .wdata   (reg_wdata),
                .status  (st_v[g]),
                .mask    (mk_v[g]),
                .req     (rq_v[g])
            );
        end
    endgenerate

    // Register read mux.
    always_comb begin
        unique case (sel_off)
            OFF_STAT: reg_rdata = st_v[sel_bank];
            OFF_REQ:  reg_rdata = rq_v[sel_bank];
            OFF_MASK: reg_rdata = mk_v[sel_bank];
            default:  reg_rdata = '0;
        endcase
    end

    // Summary interrupt lines.
    always_comb begin
        irq = (|rq_v[BK_A]) | (|rq_v[BK_B]) | (|rq_v[BK_DMA]);
        fiq = |rq_v[BK_FIQ];
    end

    logic [BANK_W-DMA_W-1:0] unused_dma_hi;
    assign unused_dma_hi = rq_v[BK_DMA][BANK_W-1:DMA_W];

    intc_resolver u_res (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_a     (rq_v[BK_A]),
        .req_b     (rq_v[BK_B]),
        .req_dma   (rq_v[BK_DMA][DMA_W-1:0]),
        .int_valid (int_valid),
        .int_num   (int_num)
    );

    // R6: fiq is never raised by an empty fast bank.
    a_r6_fiq_source: assert property (@(posedge clk) disable iff (!rst_n)
        fiq |-> (st_v[BK_FIQ] != '0 && mk_v[BK_FIQ] != '0));
    // R2: unimplemented DMA bits always read zero.
    a_r2_dma_hi_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (st_v[BK_DMA][BANK_W-1:DMA_W] == '0) && (mk_v[BK_DMA][BANK_W-1:DMA_W] == '0));

endmodule

// File: tb/sim_prio_intc.sv
module sim_prio_intc;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [5:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [7:0] src_a = '0, src_b = '0, src_fiq = '0;
    logic [5:0] src_dma = '0;
    logic       irq, fiq, int_valid;
    logic [4:0] int_num;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    prio_intc u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_a(src_a),
        .src_b(src_b), .src_dma(src_dma), .src_fiq(src_fiq), .irq(irq),
        .fiq(fiq), .int_valid(int_valid), .int_num(int_num)
    );

    // Reference state built from the requirements.
    logic [7:0] m_st [4];
    logic [7:0] m_mk [4];
    logic [7:0] m_prev_a;
    int rank_a [8] = '{7, 5, 3, 6, 2, 0, 1, 4};
    int rank_b [8] = '{2, 3, 5, 7, 6, 0, 1, 4};

    function automatic logic [7:0] live(input int bk);
        return (bk == 2) ? 8'h3F : 8'hFF;
    endfunction

    function automatic logic [7:0] mreq(input int bk);
        return m_st[bk] & m_mk[bk];
    endfunction

    // Returns {valid, number}.
    function automatic logic [5:0] resolve();
        logic [7:0] ra = mreq(0), rb = mreq(1), rd = mreq(2);
        for (int i = 0; i < 8; i++) if (rb[rank_b[i]]) return {1'b1, 5'(8 + rank_b[i])};
        for (int i = 0; i < 6; i++) if (rd[i]) return {1'b1, 5'(16 + i)};
        for (int i = 0; i < 8; i++) if (ra[rank_a[i]]) return {1'b1, 5'(rank_a[i])};
        return 6'd0;
    endfunction

    function automatic logic [7:0] mread(input logic [5:0] a);
        int bk = int'(a[5:4]);
        case (a[3:0])
            4'h0: return m_st[bk];
            4'h4: return mreq(bk);
            4'h8: return m_mk[bk];
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int k = 0; k < 4; k++) begin
            m_st[k] = '0;
            m_mk[k] = '0;
        end
        m_prev_a = '0;
    endtask

    // One clock: drive at negedge, update model at posedge, check after it.
    task automatic step(input string tag, input logic [7:0] a, input logic [7:0] b,
                        input logic [5:0] d, input logic [7:0] f, input bit wr,
                        input logic [5:0] addr, input logic [7:0] wd);
        logic [5:0] exp_res;
        logic [7:0] edge_a, clr_a;
        int bk;
        @(negedge clk);
        src_a = a; src_b = b; src_dma = d; src_fiq = f;
        reg_wr = wr; reg_addr = addr; reg_wdata = wd;
        @(posedge clk);
        exp_res = resolve();
        bk = int'(addr[5:4]);
        edge_a = a & ~m_prev_a;
        clr_a = (wr && bk == 0 && addr[3:0] == 4'h4) ? wd : 8'h00;
        m_st[0] = (m_st[0] & ~clr_a) | edge_a;
        m_prev_a = a;
        m_st[1] = b;
        m_st[2] = {2'b00, d};
        m_st[3] = f;
        if (wr && addr[3:0] == 4'h8) m_mk[bk] = wd & live(bk);
        #1;
        chk({tag, " R6"}, "irq", 8'(irq), 8'(|(mreq(0) | mreq(1) | mreq(2))));
        chk({tag, " R6"}, "fiq", 8'(fiq), 8'(|mreq(3)));
        chk({tag, " R11"}, "int_valid", 8'(int_valid), 8'(exp_res[5]));
        if (exp_res[5]) chk({tag, " R7/R8/R9/R10"}, "int_num", 8'(int_num), 8'(exp_res[4:0]));
        chk({tag, " R2"}, "reg_rdata", reg_rdata, mread(addr));
    endtask

    initial begin
        model_reset();
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "irq", 8'(irq), 8'h0);
        chk("R1", "fiq", 8'(fiq), 8'h0);
        chk("R1", "int_valid", 8'(int_valid), 8'h0);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: mask registers read zero after reset.
        for (int k = 0; k < 4; k++) step("R1", 0, 0, 0, 0, 0, {2'(k), 4'h8}, 0);
        // Enable everything.
        for (int k = 0; k < 4; k++) step("R2", 0, 0, 0, 0, 1, {2'(k), 4'h8}, 8'hFF);
        step("R2", 0, 0, 0, 0, 0, 6'h28, 0);
        step("R2", 0, 0, 0, 0, 0, 6'h03, 0);
        // R3: pulse on bank A bit 5, then read after it falls.
        step("R3", 8'h20, 0, 0, 0, 0, 6'h00, 0);
        step("R3", 8'h00, 0, 0, 0, 0, 6'h00, 0);
        step("R3", 8'h00, 0, 0, 0, 0, 6'h00, 0);
        // R9: bank A ranking walk.
        step("R9", 8'h13, 0, 0, 0, 1, 6'h04, 8'hFF);
        step("R9", 8'h13, 0, 0, 0, 0, 6'h00, 0);
        step("R9", 8'h13, 0, 0, 0, 0, 6'h04, 0);
        step("R9", 8'h00, 0, 0, 0, 1, 6'h04, 8'h01);
        step("R9", 8'h00, 0, 0, 0, 0, 6'h00, 0);
        // R4: clear with a new edge on bit 3 in the same cycle.
        step("R4", 8'h08, 0, 0, 0, 1, 6'h04, 8'hFF);
        step("R4", 8'h08, 0, 0, 0, 0, 6'h00, 0);
        step("R4", 8'h00, 0, 0, 0, 1, 6'h04, 8'h08);
        step("R4", 8'h00, 0, 0, 0, 0, 6'h00, 0);
        // R5: clears to level banks do nothing.
        step("R5", 0, 8'h84, 6'h21, 8'h10, 0, 6'h10, 0);
        step("R5", 0, 8'h84, 6'h21, 8'h10, 1, 6'h14, 8'hFF);
        step("R5", 0, 8'h84, 6'h21, 8'h10, 1, 6'h24, 8'hFF);
        step("R5", 0, 8'h84, 6'h21, 8'h10, 0, 6'h20, 0);
        // R8: bank B ranking walk; R7: B over DMA.
        step("R8", 0, 8'h13, 6'h3F, 0, 0, 6'h14, 0);
        step("R8", 0, 8'h60, 0, 0, 0, 6'h14, 0);
        step("R8", 0, 8'h60, 0, 0, 0, 6'h14, 0);
        // R10: DMA lowest bit; R7: DMA over A.
        step("R10", 8'h80, 0, 6'h28, 0, 0, 6'h24, 0);
        step("R10", 8'h80, 0, 6'h28, 0, 0, 6'h24, 0);
        // R7: fast bank alone leaves resolver idle.
        step("R7", 0, 0, 0, 0, 1, 6'h04, 8'hFF);
        step("R7", 0, 0, 0, 8'hFF, 0, 6'h30, 0);
        step("R7", 0, 0, 0, 8'hFF, 0, 6'h34, 0);
        // Random phase.
        for (int n = 0; n < 3000; n++) begin
            logic [5:0] ad;
            logic [1:0] o;
            bit w;
            o = 2'($urandom_range(0, 3));
            ad = {2'($urandom_range(0, 3)), (o == 2'd3) ? 4'hC : {o, 2'b00}};
            w = ($urandom_range(0, 3) == 0);
            step("RND", 8'($urandom), 8'($urandom & $urandom), 6'($urandom & $urandom),
                 8'($urandom), w, ad, 8'($urandom));
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule